// File: doc/BRIEF.md
# Accumulator ALU Behind a Bus Address Window

This block is an arithmetic unit for a machine whose only instruction copies one memory word to another. The unit answers a window of eight consecutive bus addresses. A write to one of them applies the written word to an internal accumulator, and the address picks the operation: load, two subtractions, two additions, OR, AND or a halving shift. A read from the first address of the window returns the accumulator. A read from any other address in the window returns the result of a condition test on the flags.

The condition result is 2 when true and 0 when false. The sequencer can add it to the low part of a destination address, so that a program branches to one of two adjacent instructions. The accumulator is `DATA_W` bits wide. Four flags (negative, zero, overflow, carry) follow the written results. Writes take effect on the clock edge. Reads are combinational from the registered state and change nothing.

Top module: `acc_alu_window`

## Requirements
- R1: After reset the accumulator and all four flags are 0, so every read in the window returns 0.
- R2: A write to offset 0 of the window (address BASE) loads the accumulator with the data. A read of offset 0 returns the accumulator.
- R3: A write to offset 1 sets AC = AC - data. A write to offset 2 sets AC = data - AC. Carry is set when no borrow occurs, and overflow is the two's-complement overflow of the subtraction.
- R4: A write to offset 3 sets AC = data + AC. A write to offset 4 sets AC = data + AC + carry. Carry is the carry-out and overflow is the two's-complement overflow.
- R5: A write to offset 5 sets AC = data OR AC, and a write to offset 6 sets AC = AC AND data. These writes and the load at offset 0 leave overflow and carry unchanged.
- R6: A write to offset 7 sets AC to the data shifted right by one with a 0 entering the top bit. Carry takes data bit 0, and overflow is unchanged.
- R7: Every accepted write sets negative to the top bit of the new AC, and sets zero when the new AC is all zeros.
- R8: A read at offsets 1 to 7 returns a condition value: 2 when true and 0 when false. The conditions by offset are: 1 negative, 2 zero, 3 overflow, 4 carry, 5 negative XOR overflow, 6 (negative XOR overflow) OR zero, 7 carry AND NOT zero.
- R9: Reads never change the accumulator or the flags. Read data is 0 whenever the read strobe or the select is low.
- R10: A write with the select low, or to an address outside BASE..BASE+7, changes nothing. A read of an address outside the window returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Select for the decoded address range |
| addr_i | input | ADDR_W | Bus address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data: accumulator or condition value |

## Verification
The bench builds the block with DATA_W = 16, ADDR_W = 5 and BASE = 8. At a 16-bit width, random operands reach carry-out, borrow and signed overflow often. A 5-bit address adds sixteen addresses above the window, so out-of-window writes and reads are exercised alongside the window itself. Directed cases cover the wrap points 0x7FFF, 0x8000 and 0xFFFF, and the carry-in of the add-with-carry. A long random run mixes writes and reads with select and strobes switched independently.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int SLOT_W     = 3;
    localparam int SLOT_COUNT = 1 << SLOT_W;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_LOAD = 3'd0,
        SLOT_SUB  = 3'd1,
        SLOT_RSUB = 3'd2,
        SLOT_ADD  = 3'd3,
        SLOT_ADC  = 3'd4,
        SLOT_OR   = 3'd5,
        SLOT_AND  = 3'd6,
        SLOT_SHR  = 3'd7
    } slot_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BASE   = 8
) (
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output slot_e             slot_o
);
    localparam int unsigned         FIRST   = BASE;
    localparam int unsigned         LAST    = BASE + SLOT_COUNT - 1;
    localparam logic [SLOT_W-1:0]   BASE_LO = SLOT_W'(BASE);

    logic [SLOT_W-1:0] offset;

    always_comb begin
        hit_o  = sel_i && (int'(addr_i) >= FIRST) && (int'(addr_i) <= LAST);
        offset = addr_i[SLOT_W-1:0] - BASE_LO;
        slot_o = slot_e'(offset);
    end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  slot_e             slot_i,
    input  logic [DATA_W-1:0] acc_i,
    input  flags_t            flags_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] acc_o,
    output flags_t            flags_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    logic              cin;
    logic [DATA_W:0]   sum;
    logic              arith;

    always_comb begin
        op_a  = data_i;
        op_b  = acc_i;
        cin   = 1'b0;
        arith = 1'b0;
        unique case (slot_i)
            SLOT_SUB: begin
                op_a  = acc_i;
                op_b  = ~data_i;
                cin   = 1'b1;
                arith = 1'b1;
            end
            SLOT_RSUB: begin
                op_b  = ~acc_i;
                cin   = 1'b1;
                arith = 1'b1;
            end
            SLOT_ADD: arith = 1'b1;
            SLOT_ADC: begin
                cin   = flags_i.c;
                arith = 1'b1;
            end
            default: ;
        endcase

        sum = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin};

        flags_o = flags_i;
        unique case (slot_i)
            SLOT_LOAD: acc_o = data_i;
            SLOT_OR:   acc_o = data_i | acc_i;
            SLOT_AND:  acc_o = acc_i & data_i;
            SLOT_SHR: begin
                acc_o     = {1'b0, data_i[MSB:1]};
                flags_o.c = data_i[0];
            end
            default:   acc_o = sum[MSB:0];
        endcase

        if (arith) begin
            flags_o.c = sum[DATA_W];
            flags_o.v = (op_a[MSB] == op_b[MSB]) && (sum[MSB] != op_a[MSB]);
        end
        flags_o.n = acc_o[MSB];
        flags_o.z = (acc_o == '0);
    end
endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  slot_e             slot_i,
    input  logic [DATA_W-1:0] acc_i,
    input  flags_t            flags_i,
    output logic [DATA_W-1:0] value_o
);
    logic [SLOT_COUNT-1:0] truth;
    logic                  lt;

    always_comb begin
        lt                  = flags_i.n ^ flags_i.v;
        truth               = '0;
        truth[SLOT_SUB]     = flags_i.n;
        truth[SLOT_RSUB]    = flags_i.z;
        truth[SLOT_ADD]     = flags_i.v;
        truth[SLOT_ADC]     = flags_i.c;
        truth[SLOT_OR]      = lt;
        truth[SLOT_AND]     = lt | flags_i.z;
        truth[SLOT_SHR]     = flags_i.c & ~flags_i.z;

        if (slot_i == SLOT_LOAD) begin
            value_o = acc_i;
        end else begin
            value_o    = '0;
            value_o[1] = truth[slot_i];
        end
    end
endmodule

// File: rtl/acc_alu_window.sv
module acc_alu_window
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int BASE   = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [DATA_W-1:0] acc;
        flags_t            fl;
    } state_t;

    state_t            state_d;
    state_t            state_q;
    logic              hit;
    slot_e             slot;
    logic [DATA_W-1:0] exec_acc;
    flags_t            exec_fl;
    logic [DATA_W-1:0] read_val;

    acc_alu_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_decode (
        .sel_i  (sel_i),
        .addr_i (addr_i),
        .hit_o  (hit),
        .slot_o (slot)
    );

    acc_alu_exec #(
        .DATA_W (DATA_W)
    ) u_exec (
        .slot_i  (slot),
        .acc_i   (state_q.acc),
        .flags_i (state_q.fl),
        .data_i  (wdata_i),
        .acc_o   (exec_acc),
        .flags_o (exec_fl)
    );

    acc_alu_cond #(
        .DATA_W (DATA_W)
    ) u_cond (
        .slot_i  (slot),
        .acc_i   (state_q.acc),
        .flags_i (state_q.fl),
        .value_o (read_val)
    );

    always_comb begin
        state_d = state_q;
        if (hit && wr_i) begin
            state_d.acc = exec_acc;
            state_d.fl  = exec_fl;
        end
        rdata_o = (hit && rd_i) ? read_val : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int BASE   = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sel_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              rd_i,
    input logic [DATA_W-1:0] rdata_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [3:0]        flags_i
);
    localparam int MSB = DATA_W - 1;

    logic       in_win;
    logic [2:0] off;
    logic       f_n;
    logic       f_z;
    logic       f_v;
    logic       f_c;

    always_comb begin
        in_win = sel_i && (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + 8);
        off    = addr_i[2:0] - 3'(BASE);
        {f_n, f_z, f_v, f_c} = flags_i;
    end

    a_r2_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_win && wr_i && off == 3'd0) |=> (acc_i == $past(wdata_i)));

    a_r5_logic_keeps_vc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_win && wr_i && (off == 3'd0 || off == 3'd5 || off == 3'd6))
        |=> ($stable(f_v) && $stable(f_c)));

    a_r6_shift_out_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_win && wr_i && off == 3'd7) |=> (f_c == $past(wdata_i[0]) && !acc_i[MSB]));

    a_r7_nz_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_win && wr_i) |=> (f_z == (acc_i == '0) && f_n == acc_i[MSB]));

    a_r8_cond_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_win && rd_i && off != 3'd0) |-> (rdata_i == '0 || rdata_i == DATA_W'(2)));

    a_r8_negative_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_win && rd_i && off == 3'd1) |-> (rdata_i == (f_n ? DATA_W'(2) : '0)));

    a_r9_idle_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sel_i && rd_i) |-> (rdata_i == '0));

    a_r10_state_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(in_win && wr_i) |=> ($stable(acc_i) && $stable(flags_i)));
endmodule

bind acc_alu_window acc_alu_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BASE   (BASE)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rd_i    (rd_i),
    .rdata_i (rdata_o),
    .acc_i   (state_q.acc),
    .flags_i (state_q.fl)
);

// File: tb/test_acc_alu_window.sv
module test_acc_alu_window;
    localparam int  DW       = 16;
    localparam int  AW       = 5;
    localparam int  BASE     = 8;
    localparam time CLK_HALF = 5ns;
    localparam longint SPAN  = longint'(1) << DW;
    localparam longint HALF  = longint'(1) << (DW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          rd = 1'b0;
    logic [DW-1:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;

    logic [DW-1:0] m_ac = '0;
    bit mn, mz, mv, mc;

    acc_alu_window #(.DATA_W(DW), .ADDR_W(AW), .BASE(BASE)) i_acc_alu_window (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .sel_i   (sel),
        .addr_i  (addr),
        .wr_i    (wr),
        .wdata_i (wdata),
        .rd_i    (rd),
        .rdata_o (rdata)
    );

    always #(CLK_HALF) clk = ~clk;

    function automatic logic [DW-1:0] exp_read(bit s, bit r, int a);
        bit t;
        if (!s || !r || a < BASE || a > BASE + 7) return '0;
        case (a - BASE)
            0: return m_ac;
            1: t = mn;
            2: t = mz;
            3: t = mv;
            4: t = mc;
            5: t = (mn != mv);
            6: t = (mn != mv) || mz;
            default: t = mc && !mz;
        endcase
        return t ? DW'(2) : '0;
    endfunction

    function automatic longint as_signed(longint u);
        return (u >= HALF) ? u - SPAN : u;
    endfunction

    task automatic model_write(int a, logic [DW-1:0] d);
        longint ua = longint'(m_ac);
        longint ud = longint'(d);
        longint sa = as_signed(ua);
        longint sd = as_signed(ud);
        longint full;
        longint sv;
        bit arith = 1'b0;
        case (a - BASE)
            0: full = ud;
            1: begin full = ua - ud; mc = (ua >= ud); sv = sa - sd; arith = 1; end
            2: begin full = ud - ua; mc = (ud >= ua); sv = sd - sa; arith = 1; end
            3: begin full = ud + ua; mc = (full >= SPAN); sv = sd + sa; arith = 1; end
            4: begin
                full = ud + ua + longint'(mc);
                sv   = sd + sa + longint'(mc);
                mc   = (full >= SPAN);
                arith = 1;
            end
            5: full = longint'(d | m_ac);
            6: full = longint'(d & m_ac);
            default: begin full = ud / 2; mc = d[0]; end
        endcase
        if (arith) mv = (sv >= HALF) || (sv < -HALF);
        m_ac = DW'(full & (SPAN - 1));
        mn = m_ac[DW-1];
        mz = (m_ac == '0);
    endtask

    // One bus cycle: drive after the falling edge, compare read data, then clock.
    task automatic op(bit s, bit w, bit r, int a, logic [DW-1:0] d, string req);
        logic [DW-1:0] e;
        sel = s; wr = w; rd = r; addr = AW'(a); wdata = d;
        #1;
        e = exp_read(s, r, a);
        n_cmp++;
        if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s addr=%0d got=%h expected=%h", req, a, rdata, e);
        end
        @(posedge clk);
        if (s && w && a >= BASE && a <= BASE + 7) model_write(a, d);
        @(negedge clk);
    endtask

    task automatic rd_all(string req);
        for (int k = 0; k < 8; k++) op(1, 0, 1, BASE + k, '0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_all("R1 reset state");

        op(1, 1, 1, 8, 16'h1234, "R2 load");
        op(1, 0, 1, 8, '0, "R2 read acc");
        op(1, 1, 1, 8, 16'h0000, "R7 load zero");
        rd_all("R7 zero flags");
        op(1, 1, 0, 8, 16'h8000, "R7 load negative");
        rd_all("R8 negative flags");

        op(1, 1, 0, 8, 16'd5, "R3 setup");
        op(1, 1, 0, 9, 16'd7, "R3 sub borrow");
        rd_all("R3 after borrow");
        op(1, 1, 0, 8, 16'h8000, "R3 setup");
        op(1, 1, 0, 9, 16'd1, "R3 sub overflow");
        rd_all("R3 overflow flags");
        op(1, 1, 0, 10, 16'd3, "R3 reverse sub");
        rd_all("R3 reverse result");

        op(1, 1, 0, 8, 16'hFFFF, "R4 setup");
        op(1, 1, 0, 11, 16'd1, "R4 add carry");
        rd_all("R4 wrap to zero");
        op(1, 1, 0, 12, 16'd4, "R4 adc carry in");
        rd_all("R4 adc result");
        op(1, 1, 0, 8, 16'h7FFF, "R4 setup");
        op(1, 1, 0, 11, 16'd1, "R4 add overflow");
        rd_all("R4 overflow flags");

        op(1, 1, 0, 13, 16'h00F0, "R5 or");
        op(1, 1, 0, 14, 16'h0FF0, "R5 and");
        rd_all("R5 logic keeps vc");

        op(1, 1, 0, 15, 16'h0003, "R6 shift");
        rd_all("R6 shift carry");
        op(1, 1, 0, 15, 16'hFFFE, "R6 shift even");
        rd_all("R6 shift result");

        op(0, 1, 1, 8, 16'hAAAA, "R10 deselected write");
        op(1, 1, 1, 20, 16'hBBBB, "R10 out of window");
        op(1, 1, 1, 3, 16'hCCCC, "R10 below window");
        rd_all("R10 state unchanged");
        op(1, 0, 0, 8, '0, "R9 no read strobe");
        op(0, 0, 1, 8, '0, "R9 no select");
        rd_all("R9 reads quiet");

        for (int i = 0; i < 600; i++) begin
            int a = (($urandom % 4) == 0) ? int'($urandom % 32) : BASE + int'($urandom % 8);
            op(($urandom % 8) != 0, ($urandom % 3) != 0, ($urandom % 2) == 0, a,
               DW'($urandom), "R8 random mix");
            op(1, 0, 1, BASE + int'($urandom % 8), '0, "R8 random probe");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule